// File: doc/BRIEF.md
# Quadrature Encoder Position Counter

This block turns the two phase signals and the index signal of an incremental rotary encoder into a signed-free 24-bit position count. Each of the three inputs is brought into the clock domain by a two-stage synchronizer. It then passes through a glitch filter whose minimum accepted pulse width is chosen by a 2-bit select. The filtered phases are decoded as a Gray-code sequence. Each legal step moves the counter up or down and updates a direction flag. A step in which both phases move together is reported as a revolution error and leaves the count alone.

Status flags for index seen, compare match and revolution error are cleared by a one-cycle read strobe. A set event in the same cycle as the read wins over the clear. An optional interrupt pulse marks new events. A timer mode makes the counter run on the system clock. In that mode the chosen index edge can latch the count into a capture register and restart the count from zero, which gives a period measurement. Dropping the run enable stops the block and zeroes its working state. The capture register and the revolution-error flag keep their values through this and are cleared only by reset or, for the flag, by a read.

Top module: `qenc_top`

## Requirements
- R1: While runEn is 0, count, dirUp, zFlag and cmpFlag are forced to 0 and no events occur. The input filters keep running.
- R2: Every input passes two synchronizer flops and then a filter. fltSel 00 passes every level change. For 01, 10 and 11 a new level is accepted only when it lasts at least 31, 63 or 127 clocks. Shorter pulses are dropped.
- R3: In encoder mode (timerMode=0), the phase order {A,B} = 00→10→11→01→00 adds one per step and sets dirUp to 1. The reverse order subtracts one per step and sets dirUp to 0. The 24-bit count wraps in both directions.
- R4: If both filtered phases change in the same clock, revErr is set, and count and dirUp keep their values.
- R5: revErr is cleared only by rdStatus or reset. Dropping runEn leaves it unchanged.
- R6: zFlag is set on the index edge picked by zEdgeSel (1 = rising, 0 = falling) and cleared by rdStatus. A set in the same cycle as a read wins.
- R7: With timerMode=1 the count rises by one every clock. If zEnable is also 1, the selected index edge copies the count into capture and restarts the count at 0. With zEnable=0, or in encoder mode, capture is never written.
- R8: cmpFlag is set while count equals cmpValue and runEn is 1, and is cleared by rdStatus unless the match still holds.
- R9: irq is a one-clock pulse for each index event, each revolution error and each 0→1 set of cmpFlag. It is produced only while intEn is 1.
- R10: A one-cycle swClear returns count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Run enable |
| fltSel | input | 2 | Glitch filter width select |
| intEn | input | 1 | Interrupt enable |
| zEdgeSel | input | 1 | Index edge select, 1 rising, 0 falling |
| zEnable | input | 1 | Index capture/restart enable in timer mode |
| timerMode | input | 1 | 1: count clocks, 0: decode encoder |
| swClear | input | 1 | Counter clear strobe |
| rdStatus | input | 1 | Status read strobe, clears flags |
| cmpValue | input | 24 | Compare value |
| encA | input | 1 | Phase A input |
| encB | input | 1 | Phase B input |
| encZ | input | 1 | Index input |
| count | output | 24 | Position / timer count |
| capture | output | 24 | Captured count |
| dirUp | output | 1 | Last step direction, 1 = up |
| zFlag | output | 1 | Index detected flag |
| cmpFlag | output | 1 | Compare match flag |
| revErr | output | 1 | Revolution error flag |
| irq | output | 1 | Interrupt pulse |

## Verification
The hardest condition to reach from the pins is a filter width exactly at its limit. The edge of the count comes several synchronizer and filter stages after the stimulus. To reach it, the bench holds a phase high for exactly 30 and then 31 clocks, and for 126 and then 127 clocks. It watches the count on every cycle of the pulse and afterwards, so the boundary result does not depend on guessing the cycle of the update. A revolution error is forced by moving both phases at the same falling edge. The timer capture is checked against a window of clock counts and is not required to land on one exact cycle.

// File: rtl/qenc_pkg.sv
package qenc_pkg;
  typedef struct packed {
    logic inc;
    logic dec;
    logic tick;
    logic capClr;
    logic clr;
  } qencStb_t;
endpackage

// File: rtl/qenc_filter.sv
module qenc_filter #(
  parameter int FSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [FSEL_W-1:0] sel,
  input  logic              din,
  output logic              dout
);
  localparam int BASE_SH = 4;
  localparam int FCNT_W  = (2 ** FSEL_W) + BASE_SH - 1;

  logic [1:0]        syncQ;
  logic [FCNT_W-1:0] runLen;
  logic [FCNT_W-1:0] limit;
  logic              outQ;

  always_comb begin
    if (sel == '0) limit = '0;
    else limit = FCNT_W'((32'd1 << (32'(sel) + 32'(BASE_SH))) - 32'd2);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ  <= '0;
      runLen <= '0;
      outQ   <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], din};
      if (syncQ[1] == outQ) begin
        runLen <= '0;
      end else if (runLen >= limit) begin
        outQ   <= syncQ[1];
        runLen <= '0;
      end else begin
        runLen <= runLen + 1'b1;
      end
    end
  end

  assign dout = outQ;

  // R2: the output only ever moves to the level the synchronizer held
  assert_filter_follows_sync_R2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outQ) |-> (outQ == $past(syncQ[1])));
endmodule

// File: rtl/qenc_ctrl.sv
module qenc_ctrl
  import qenc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             runEn,
  input  logic             timerMode,
  input  logic             zEnable,
  input  logic             zEdgeSel,
  input  logic             intEn,
  input  logic             rdStatus,
  input  logic             swClear,
  input  logic             fA,
  input  logic             fB,
  input  logic             fZ,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmpValue,
  output qencStb_t         stb,
  output logic             dirUp,
  output logic             zFlag,
  output logic             cmpFlag,
  output logic             revErr,
  output logic             irq
);
  logic prevA, prevB, prevZ;
  logic aChg, bChg, stepOk, stepUp, errEvt, zEvt, capEvt, cmpHit, cmpNew;

  always_comb begin
    aChg   = fA ^ prevA;
    bChg   = fB ^ prevB;
    stepOk = runEn & ~timerMode & (aChg ^ bChg);
    stepUp = fA ^ prevB;
    errEvt = runEn & ~timerMode & aChg & bChg;
    zEvt   = runEn & (zEdgeSel ? (fZ & ~prevZ) : (~fZ & prevZ));
    capEvt = zEvt & timerMode & zEnable;
    cmpHit = runEn & (cnt == cmpValue);
    cmpNew = cmpHit & ~cmpFlag;

    stb.inc    = stepOk & stepUp;
    stb.dec    = stepOk & ~stepUp;
    stb.tick   = runEn & timerMode;
    stb.capClr = capEvt;
    stb.clr    = ~runEn | swClear;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevA   <= 1'b0;
      prevB   <= 1'b0;
      prevZ   <= 1'b0;
      dirUp   <= 1'b0;
      zFlag   <= 1'b0;
      cmpFlag <= 1'b0;
      revErr  <= 1'b0;
      irq     <= 1'b0;
    end else begin
      prevA <= fA;
      prevB <= fB;
      prevZ <= fZ;
      irq   <= intEn & (zEvt | errEvt | cmpNew);

      if (errEvt)        revErr <= 1'b1;
      else if (rdStatus) revErr <= 1'b0;

      if (!runEn) begin
        dirUp   <= 1'b0;
        zFlag   <= 1'b0;
        cmpFlag <= 1'b0;
      end else begin
        if (stb.inc)      dirUp <= 1'b1;
        else if (stb.dec) dirUp <= 1'b0;

        if (zEvt)          zFlag <= 1'b1;
        else if (rdStatus) zFlag <= 1'b0;

        if (cmpHit)        cmpFlag <= 1'b1;
        else if (rdStatus) cmpFlag <= 1'b0;
      end
    end
  end

  assert_idle_flags_clear_R1: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!dirUp && !zFlag && !cmpFlag));

  assert_double_change_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    errEvt |=> (revErr && dirUp == $past(dirUp)));

  assert_err_survives_stop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (revErr && !rdStatus) |=> revErr);

  assert_dir_tracks_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && stepOk) |=> (dirUp == $past(stepUp)));

  assert_irq_needs_enable_R9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> $past(intEn));
endmodule

// File: rtl/qenc_dp.sv
module qenc_dp
  import qenc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  qencStb_t         stb,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cap
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
      cap <= '0;
    end else if (stb.clr) begin
      cnt <= '0;
    end else if (stb.capClr) begin
      cap <= cnt;
      cnt <= '0;
    end else if (stb.inc || stb.tick) begin
      cnt <= cnt + 1'b1;
    end else if (stb.dec) begin
      cnt <= cnt - 1'b1;
    end
  end

  assert_clear_zeroes_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.clr |=> (cnt == '0));

  assert_up_step_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.inc && !stb.clr && !stb.capClr) |=> (cnt == $past(cnt) + 1'b1));

  assert_capture_restart_R7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.capClr && !stb.clr) |=> (cnt == '0 && cap == $past(cnt)));

  assert_capture_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capClr |=> $stable(cap));
endmodule

// File: rtl/qenc_top.sv
module qenc_top
  import qenc_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int FSEL_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [FSEL_W-1:0] fltSel,
  input  logic              intEn,
  input  logic              zEdgeSel,
  input  logic              zEnable,
  input  logic              timerMode,
  input  logic              swClear,
  input  logic              rdStatus,
  input  logic [CNT_W-1:0]  cmpValue,
  input  logic              encA,
  input  logic              encB,
  input  logic              encZ,
  output logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  capture,
  output logic              dirUp,
  output logic              zFlag,
  output logic              cmpFlag,
  output logic              revErr,
  output logic              irq
);
  localparam int N_IN = 3;

  logic [N_IN-1:0] rawIn;
  logic [N_IN-1:0] fltIn;
  qencStb_t        stb;

  assign rawIn = {encZ, encB, encA};

  for (genvar gi = 0; gi < N_IN; gi++) begin : g_flt
    qenc_filter #(.FSEL_W(FSEL_W)) u_flt (
      .clk  (clk),
      .rstN (rstN),
      .sel  (fltSel),
      .din  (rawIn[gi]),
      .dout (fltIn[gi])
    );
  end

  qenc_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .timerMode (timerMode),
    .zEnable   (zEnable),
    .zEdgeSel  (zEdgeSel),
    .intEn     (intEn),
    .rdStatus  (rdStatus),
    .swClear   (swClear),
    .fA        (fltIn[0]),
    .fB        (fltIn[1]),
    .fZ        (fltIn[2]),
    .cnt       (count),
    .cmpValue  (cmpValue),
    .stb       (stb),
    .dirUp     (dirUp),
    .zFlag     (zFlag),
    .cmpFlag   (cmpFlag),
    .revErr    (revErr),
    .irq       (irq)
  );

  qenc_dp #(.CNT_W(CNT_W)) u_dp (
    .clk  (clk),
    .rstN (rstN),
    .stb  (stb),
    .cnt  (count),
    .cap  (capture)
  );
endmodule

// File: tb/sim_qenc_top.sv
module sim_qenc_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        runEn = 1'b0;
  logic [1:0]  fltSel = 2'b00;
  logic        intEn = 1'b0;
  logic        zEdgeSel = 1'b1;
  logic        zEnable = 1'b0;
  logic        timerMode = 1'b0;
  logic        swClear = 1'b0;
  logic        rdStatus = 1'b0;
  logic [23:0] cmpValue = 24'h800000;
  logic        encA = 1'b0;
  logic        encB = 1'b0;
  logic        encZ = 1'b0;
  logic [23:0] count;
  logic [23:0] capture;
  logic        dirUp, zFlag, cmpFlag, revErr, irq;

  int nChecks = 0;
  int nFails  = 0;
  int irqCnt  = 0;
  bit done    = 0;

  always #10 clk = ~clk;

  always @(posedge clk) if (rstN && irq) irqCnt++;

  qenc_top u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .fltSel(fltSel), .intEn(intEn),
    .zEdgeSel(zEdgeSel), .zEnable(zEnable), .timerMode(timerMode),
    .swClear(swClear), .rdStatus(rdStatus), .cmpValue(cmpValue),
    .encA(encA), .encB(encB), .encZ(encZ), .count(count), .capture(capture),
    .dirUp(dirUp), .zFlag(zFlag), .cmpFlag(cmpFlag), .revErr(revErr), .irq(irq)
  );

  // {a, b, expDir, expErr, expCount}
  localparam int NV = 12;
  localparam logic [27:0] VEC [NV] = '{
    {1'b1, 1'b0, 1'b1, 1'b0, 24'd1},
    {1'b1, 1'b1, 1'b1, 1'b0, 24'd2},
    {1'b0, 1'b1, 1'b1, 1'b0, 24'd3},
    {1'b0, 1'b0, 1'b1, 1'b0, 24'd4},
    {1'b0, 1'b1, 1'b0, 1'b0, 24'd3},
    {1'b1, 1'b1, 1'b0, 1'b0, 24'd2},
    {1'b1, 1'b0, 1'b0, 1'b0, 24'd1},
    {1'b0, 1'b0, 1'b0, 1'b0, 24'd0},
    {1'b0, 1'b1, 1'b0, 1'b0, 24'hFFFFFF},
    {1'b0, 1'b0, 1'b1, 1'b0, 24'd0},
    {1'b1, 1'b0, 1'b1, 1'b0, 24'd1},
    {1'b0, 1'b1, 1'b1, 1'b1, 24'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drivePhases(input logic a, input logic b);
    @(negedge clk);
    encA = a;
    encB = b;
    waitN(6);
  endtask

  task automatic pulseRead();
    @(negedge clk);
    rdStatus = 1'b1;
    @(negedge clk);
    rdStatus = 1'b0;
    waitN(2);
  endtask

  // Hold A high for w clocks, watch the count for tgt during and after the pulse
  task automatic pulseA(input int w, input logic [23:0] tgt, output bit seen);
    seen = 0;
    @(negedge clk);
    encA = 1'b1;
    repeat (w) begin
      @(negedge clk);
      if (count == tgt) seen = 1;
    end
    encA = 1'b0;
    repeat (300) begin
      @(negedge clk);
      if (count == tgt) seen = 1;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    bit seen;
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    // reset state
    chk("R1 reset count", 32'(count), 32'd0);
    chk("R7 reset capture", 32'(capture), 32'd0);
    chk("R1 reset flags", {28'd0, dirUp, zFlag, cmpFlag, revErr}, 32'd0);
    chk("R9 reset irq", 32'(irq), 32'd0);

    // table walk, encoder mode, no filtering
    @(negedge clk);
    runEn = 1'b1;
    waitN(2);
    for (int i = 0; i < NV; i++) begin
      drivePhases(VEC[i][27], VEC[i][26]);
      chk("R3 R4 table count", 32'(count), 32'(VEC[i][23:0]));
      chk("R3 R4 table dir", 32'(dirUp), 32'(VEC[i][25]));
      chk("R4 table revErr", 32'(revErr), 32'(VEC[i][24]));
    end
    chk("R9 no irq while disabled", 32'(irqCnt), 32'd0);

    // stop: state cleared, revErr kept
    @(negedge clk);
    runEn = 1'b0;
    encA = 1'b0;
    encB = 1'b0;
    waitN(8);
    chk("R1 stopped count", 32'(count), 32'd0);
    chk("R1 stopped dir", 32'(dirUp), 32'd0);
    chk("R5 revErr kept on stop", 32'(revErr), 32'd1);
    pulseRead();
    chk("R5 revErr read clear", 32'(revErr), 32'd0);

    // software clear
    @(negedge clk);
    runEn = 1'b1;
    waitN(2);
    drivePhases(1'b1, 1'b0);
    drivePhases(1'b1, 1'b1);
    chk("R3 count before clear", 32'(count), 32'd2);
    @(negedge clk);
    swClear = 1'b1;
    @(negedge clk);
    swClear = 1'b0;
    waitN(1);
    chk("R10 software clear", 32'(count), 32'd0);

    // compare and interrupt
    @(negedge clk);
    cmpValue = 24'd1;
    intEn = 1'b1;
    drivePhases(1'b0, 1'b1);
    chk("R8 compare set", 32'(cmpFlag), 32'd1);
    chk("R9 irq on compare", 32'(irqCnt), 32'd1);
    pulseRead();
    chk("R8 match holds flag", 32'(cmpFlag), 32'd1);
    drivePhases(1'b0, 1'b0);
    pulseRead();
    chk("R8 compare read clear", 32'(cmpFlag), 32'd0);
    chk("R9 single irq", 32'(irqCnt), 32'd1);
    @(negedge clk);
    intEn = 1'b0;
    cmpValue = 24'h800000;

    // index edge selection
    @(negedge clk);
    zEdgeSel = 1'b0;
    zEnable = 1'b1;
    encZ = 1'b1;
    waitN(6);
    chk("R6 rising ignored on falling select", 32'(zFlag), 32'd0);
    @(negedge clk);
    encZ = 1'b0;
    waitN(6);
    chk("R6 falling edge sets", 32'(zFlag), 32'd1);
    pulseRead();
    chk("R6 read clears", 32'(zFlag), 32'd0);
    @(negedge clk);
    zEdgeSel = 1'b1;
    encZ = 1'b1;
    waitN(6);
    chk("R6 rising edge sets", 32'(zFlag), 32'd1);
    chk("R7 no capture in encoder mode", 32'(capture), 32'd0);
    chk("R9 no irq on index when disabled", 32'(irqCnt), 32'd1);
    @(negedge clk);
    encZ = 1'b0;
    waitN(6);
    pulseRead();

    // filter boundaries, count is 2 and phases are 00
    @(negedge clk);
    fltSel = 2'b01;
    pulseA(30, 24'd3, seen);
    chk("R2 30-clock pulse rejected", 32'(seen), 32'd0);
    pulseA(31, 24'd3, seen);
    chk("R2 31-clock pulse accepted", 32'(seen), 32'd1);
    chk("R2 count back after pulse", 32'(count), 32'd2);
    @(negedge clk);
    fltSel = 2'b11;
    pulseA(126, 24'd3, seen);
    chk("R2 126-clock pulse rejected", 32'(seen), 32'd0);
    pulseA(127, 24'd3, seen);
    chk("R2 127-clock pulse accepted", 32'(seen), 32'd1);

    // timer mode with capture
    @(negedge clk);
    fltSel = 2'b00;
    cmpValue = 24'hFFFFF0;
    zEnable = 1'b1;
    zEdgeSel = 1'b1;
    timerMode = 1'b1;
    waitN(40);
    chk("R7 timer counts clocks", 32'(count >= 24'd38 && count <= 24'd42), 32'd1);
    @(negedge clk);
    encZ = 1'b1;
    waitN(6);
    chk("R7 capture window", 32'(capture >= 24'd40 && capture <= 24'd50), 32'd1);
    chk("R7 restart after capture", 32'(count < 24'd10), 32'd1);
    @(negedge clk);
    zEnable = 1'b0;
    encZ = 1'b0;
    waitN(6);
    begin
      logic [23:0] held;
      held = capture;
      @(negedge clk);
      encZ = 1'b1;
      waitN(20);
      chk("R7 zEnable low keeps capture", 32'(capture), 32'(held));
      chk("R7 zEnable low keeps counting", 32'(count > 24'd25), 32'd1);
    end

    done = 1;
    summary();
    $finish;
  end
endmodule